// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the per-pin configuration and data state for a small bank of general-purpose pins and turns it into the control signals a pad cell needs. Every pin owns two words on a shared register port. The control word holds a function index, a bias mode, a drive-strength code and an output enable. The data word holds the stored output level and the synchronized pad level. Software writes the words with a single-cycle strobe. A read strobe returns the addressed word one cycle later.

On the pad side, each pin presents an output value, an output enable, pull-up, pull-down and keeper requests, a keeper level, the drive code and the selected function index. Function index zero connects the pad to the pin's own output and enable bits. Any other index passes the alternate-function output and enable straight through. The incoming pad level passes through a two-flop synchronizer. It is read back through the data word, and in keeper mode it sets the level the keeper holds.

The bank has no state machine. All behaviour is per-pin register state plus combinational decode.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every pin has function 0, bias code 0, drive code 0, output enable 0 and output bit 0. The pad-side pad_oe, pad_pu, pad_pd, pad_keep, pad_drive and pad_func are all zero, and reg_rdata is zero.
- R2: reg_addr bit 0 selects the word (0 = control, 1 = data), and the upper address bits give the pin index. In the control word, bits [2:0] hold the drive code, bits [5:4] the bias code, bit 7 the output enable and bits starting at bit 8 the function index. All other bits read as 0. reg_rdata presents the addressed word on the clock edge that samples reg_rd.
- R3: The bias code decodes as follows: 0 requests no pull, 1 asserts pad_pd, 2 asserts pad_keep and 3 asserts pad_pu. At most one of the three is high.
- R4: A pin's 3-bit drive code, whose value v requests (v+1)*2 mA (2 to 16 mA), appears unchanged on that pin's pad_drive slice. All eight codes are accepted.
- R5: Data-word bit 0 is the stored output bit and can be written and read back. Bit 1 is the synchronized input and is read-only: writes to it are ignored.
- R6: A change on pad_in becomes visible internally, through the data word and the keeper level, after exactly two rising clock edges.
- R7: With function 0, pad_out equals the stored output bit and pad_oe equals the output enable bit.
- R8: With a nonzero function, pad_out and pad_oe follow alt_out and alt_oe. The stored output bit and enable are kept and take effect again when function 0 returns.
- R9: With bias code 2 and pad_oe low, pad_keep_val follows the synchronized input. Otherwise it holds its last value.
- R10: A control write whose function index is NUM_FUNCS or larger leaves the function field unchanged but still updates drive, bias and enable.
- R11: Accesses to pin indices of NUM_PINS or above are ignored on write and return 0 on read.
- R12: pad_func carries each pin's stored function index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | {pin index, word select} |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| alt_out | input | NUM_PINS | Alternate-function output values |
| alt_oe | input | NUM_PINS | Alternate-function output enables |
| pad_out | output | NUM_PINS | Pad output value |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pu | output | NUM_PINS | Pull-up request |
| pad_pd | output | NUM_PINS | Pull-down request |
| pad_keep | output | NUM_PINS | Keeper enable |
| pad_keep_val | output | NUM_PINS | Level the keeper holds |
| pad_drive | output | 3*NUM_PINS | Drive code per pin |
| pad_func | output | FSEL_W*NUM_PINS | Function index per pin |

## Verification
The bench builds the bank with its defaults: six pins and five functions. The function field is therefore three bits wide, so indices 5 to 7 exist in the field and can be used to exercise rejection of an illegal function index. The six pins leave pin indices 6 and 7 decodable but unpopulated, which brings the ignored-write and zero-read paths within reach. The keeper level is observable at a port, so the two-edge synchronizer latency can be checked on its exact cycle.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int DRV_W         = 3;
    localparam int BIAS_W        = 2;
    localparam int CTRL_DRV_LSB  = 0;
    localparam int CTRL_BIAS_LSB = 4;
    localparam int CTRL_OE_BIT   = 7;
    localparam int CTRL_FUNC_LSB = 8;
    localparam int DATA_OUT_BIT  = 0;
    localparam int DATA_IN_BIT   = 1;

    typedef enum logic [BIAS_W-1:0] {
        BIAS_NONE = 2'd0,
        BIAS_DOWN = 2'd1,
        BIAS_KEEP = 2'd2,
        BIAS_UP   = 2'd3
    } bias_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int NUM_FUNCS = 5,
    parameter int FSEL_W    = 3,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pad_in,
    input  logic              alt_out,
    input  logic              alt_oe,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] data_word,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              pad_pu,
    output logic              pad_pd,
    output logic              pad_keep,
    output logic              pad_keep_val,
    output logic [DRV_W-1:0]  pad_drive,
    output logic [FSEL_W-1:0] pad_func
);

    logic [FSEL_W-1:0] func_q;
    bias_e             bias_q;
    logic [DRV_W-1:0]  drv_q;
    logic              oe_q;
    logic              out_q;
    logic              keep_q;
    logic              sync_in;
    logic [FSEL_W-1:0] wr_func;
    logic              wr_func_ok;
    logic              keep_track;

    gpio_pad_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_in)
    );

    assign wr_func    = wdata[CTRL_FUNC_LSB +: FSEL_W];
    assign wr_func_ok = (int'(wr_func) < NUM_FUNCS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q <= '0;
            bias_q <= BIAS_NONE;
            drv_q  <= '0;
            oe_q   <= 1'b0;
            out_q  <= 1'b0;
            keep_q <= 1'b0;
        end else begin
            if (ctrl_we) begin
                drv_q  <= wdata[CTRL_DRV_LSB +: DRV_W];
                bias_q <= bias_e'(wdata[CTRL_BIAS_LSB +: BIAS_W]);
                oe_q   <= wdata[CTRL_OE_BIT];
                if (wr_func_ok) begin
                    func_q <= wr_func;
                end
            end
            if (data_we) begin
                out_q <= wdata[DATA_OUT_BIT];
            end
            keep_q <= pad_keep_val;
        end
    end

    always_comb begin
        if (func_q == '0) begin
            pad_out = out_q;
            pad_oe  = oe_q;
        end else begin
            pad_out = alt_out;
            pad_oe  = alt_oe;
        end
    end

    always_comb begin
        pad_pu   = 1'b0;
        pad_pd   = 1'b0;
        pad_keep = 1'b0;
        unique case (bias_q)
            BIAS_NONE: ;
            BIAS_DOWN: pad_pd   = 1'b1;
            BIAS_KEEP: pad_keep = 1'b1;
            BIAS_UP:   pad_pu   = 1'b1;
            default:   ;
        endcase
    end

    assign keep_track   = (bias_q == BIAS_KEEP) && !pad_oe;
    assign pad_keep_val = keep_track ? sync_in : keep_q;
    assign pad_drive    = drv_q;
    assign pad_func     = func_q;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_DRV_LSB +: DRV_W]     = drv_q;
        ctrl_word[CTRL_BIAS_LSB +: BIAS_W]   = bias_q;
        ctrl_word[CTRL_OE_BIT]               = oe_q;
        ctrl_word[CTRL_FUNC_LSB +: FSEL_W]   = func_q;
        data_word = '0;
        data_word[DATA_OUT_BIT] = out_q;
        data_word[DATA_IN_BIT]  = sync_in;
    end

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    a_r6_sync_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (sync_in == $past(pad_in, 2)));

    a_r9_keep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !keep_track |=> (keep_track || $stable(pad_keep_val)));

    a_r10_func_legal: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pad_func) < NUM_FUNCS);

    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_word));

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PINS  = 6,
    parameter int NUM_FUNCS = 5,
    parameter int DATA_W    = 16,
    localparam int FSEL_W   = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
    localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int ADDR_W   = PIN_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [NUM_PINS-1:0]        pad_in,
    input  logic [NUM_PINS-1:0]        alt_out,
    input  logic [NUM_PINS-1:0]        alt_oe,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [NUM_PINS-1:0]        pad_pu,
    output logic [NUM_PINS-1:0]        pad_pd,
    output logic [NUM_PINS-1:0]        pad_keep,
    output logic [NUM_PINS-1:0]        pad_keep_val,
    output logic [3*NUM_PINS-1:0]      pad_drive,
    output logic [FSEL_W*NUM_PINS-1:0] pad_func
);

    logic [PIN_W-1:0]  pin_idx;
    logic              word_sel;
    logic              pin_ok;
    logic [DATA_W-1:0] ctrl_words [NUM_PINS];
    logic [DATA_W-1:0] data_words [NUM_PINS];
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign pin_idx  = reg_addr[ADDR_W-1:1];
    assign word_sel = reg_addr[0];
    assign pin_ok   = (int'(pin_idx) < NUM_PINS);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic hit;
        assign hit = reg_wr && pin_ok && (int'(pin_idx) == g);

        gpio_pin_ctrl #(
            .NUM_FUNCS (NUM_FUNCS),
            .FSEL_W    (FSEL_W),
            .DATA_W    (DATA_W)
        ) u_pin (
            .clk          (clk),
            .rst_n        (rst_n),
            .ctrl_we      (hit && !word_sel),
            .data_we      (hit && word_sel),
            .wdata        (reg_wdata),
            .pad_in       (pad_in[g]),
            .alt_out      (alt_out[g]),
            .alt_oe       (alt_oe[g]),
            .ctrl_word    (ctrl_words[g]),
            .data_word    (data_words[g]),
            .pad_out      (pad_out[g]),
            .pad_oe       (pad_oe[g]),
            .pad_pu       (pad_pu[g]),
            .pad_pd       (pad_pd[g]),
            .pad_keep     (pad_keep[g]),
            .pad_keep_val (pad_keep_val[g]),
            .pad_drive    (pad_drive[3*g +: 3]),
            .pad_func     (pad_func[FSEL_W*g +: FSEL_W])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pin_ok && (int'(pin_idx) == i)) begin
                rd_mux = word_sel ? data_words[i] : ctrl_words[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign reg_rdata = rdata_q;

    a_r11_unpopulated_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !pin_ok) |=> (reg_rdata == '0));

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/tb_gpio_pad_bank.sv
`timescale 1ns/1ps
module tb_gpio_pad_bank;

    localparam int NP = 6;
    localparam int FW = 3;
    localparam int AW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   alt_out = '0;
    logic [NP-1:0]   alt_oe = '0;
    logic [NP-1:0]   pad_out, pad_oe, pad_pu, pad_pd, pad_keep, pad_keep_val;
    logic [3*NP-1:0] pad_drive;
    logic [FW*NP-1:0] pad_func;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_pad_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_keep(pad_keep), .pad_keep_val(pad_keep_val),
        .pad_drive(pad_drive), .pad_func(pad_func)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_ctrl(int func, int oe, int bias, int drv);
        return 16'((func << 8) | (oe << 7) | (bias << 4) | drv);
    endfunction

    task automatic wr(input int pin, input int word, input logic [15:0] d);
        @(negedge clk);
        reg_addr = AW'((pin << 1) | word);
        reg_wdata = d;
        reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int pin, input int word, output logic [15:0] d);
        @(negedge clk);
        reg_addr = AW'((pin << 1) | word);
        reg_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 bias outputs", 32'({pad_pu, pad_pd, pad_keep}), 0);
        chk("R1 pad_drive", 32'(pad_drive), 0);
        chk("R1 pad_func", 32'(pad_func), 0);
        chk("R1 reg_rdata", 32'(reg_rdata), 0);
        rd(0, 0, d);
        chk("R1 ctrl word", 32'(d), 0);
        rd(5, 1, d);
        chk("R1 data word", 32'(d), 0);
    endtask

    task automatic t_bias();
        logic [15:0] d;
        for (int b = 0; b < 4; b++) begin
            wr(1, 0, mk_ctrl(0, 0, b, 0));
            chk("R3 pu", 32'(pad_pu[1]), 32'(b == 3));
            chk("R3 pd", 32'(pad_pd[1]), 32'(b == 1));
            chk("R3 keep", 32'(pad_keep[1]), 32'(b == 2));
        end
        wr(1, 0, 16'hF3B7);
        rd(1, 0, d);
        chk("R2 ctrl layout and unused bits", 32'(d), 32'h03B7);
        chk("R12 pad_func", 32'(pad_func[FW*1 +: FW]), 3);
    endtask

    task automatic t_drive();
        logic [15:0] d;
        for (int v = 0; v < 8; v++) begin
            wr(2, 0, mk_ctrl(0, 0, 0, v));
            chk("R4 pad_drive", 32'(pad_drive[3*2 +: 3]), 32'(v));
            rd(2, 0, d);
            chk("R4 drive readback", 32'(d), 32'(v));
        end
    endtask

    task automatic t_data();
        logic [15:0] d;
        wr(3, 0, mk_ctrl(0, 1, 0, 0));
        wr(3, 1, 16'h0003);
        rd(3, 1, d);
        chk("R5 input bit not writable", 32'(d), 1);
        chk("R7 pad_out", 32'(pad_out[3]), 1);
        chk("R7 pad_oe", 32'(pad_oe[3]), 1);
        pad_in[3] = 1'b1;
        repeat (3) @(negedge clk);
        wr(3, 1, 16'h0000);
        rd(3, 1, d);
        chk("R5 input bit from pad", 32'(d), 2);
        chk("R7 pad_out low", 32'(pad_out[3]), 0);
    endtask

    task automatic t_sync_keep();
        wr(4, 0, mk_ctrl(0, 0, 2, 0));
        chk("R3 keeper enable", 32'(pad_keep[4]), 1);
        pad_in[4] = 1'b1;
        @(negedge clk);
        chk("R6 one edge not yet", 32'(pad_keep_val[4]), 0);
        @(negedge clk);
        chk("R6 two edges", 32'(pad_keep_val[4]), 1);
        wr(4, 0, mk_ctrl(0, 1, 2, 0));
        pad_in[4] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 hold while driven", 32'(pad_keep_val[4]), 1);
        wr(4, 0, mk_ctrl(0, 0, 2, 0));
        chk("R9 tracks again", 32'(pad_keep_val[4]), 0);
    endtask

    task automatic t_alt();
        wr(5, 1, 16'h0001);
        wr(5, 0, mk_ctrl(3, 0, 0, 0));
        chk("R12 pad_func alt", 32'(pad_func[FW*5 +: FW]), 3);
        alt_out[5] = 1'b0;
        alt_oe[5] = 1'b1;
        @(negedge clk);
        chk("R8 alt out", 32'(pad_out[5]), 0);
        chk("R8 alt oe", 32'(pad_oe[5]), 1);
        alt_oe[5] = 1'b0;
        alt_out[5] = 1'b1;
        @(negedge clk);
        chk("R8 alt oe low", 32'(pad_oe[5]), 0);
        chk("R8 alt out high", 32'(pad_out[5]), 1);
        alt_out[5] = 1'b0;
        wr(5, 0, mk_ctrl(0, 1, 0, 0));
        chk("R8 stored out restored", 32'(pad_out[5]), 1);
        chk("R8 stored oe restored", 32'(pad_oe[5]), 1);
    endtask

    task automatic t_bad_func();
        logic [15:0] d;
        wr(0, 0, mk_ctrl(2, 0, 0, 0));
        wr(0, 0, mk_ctrl(6, 0, 3, 5));
        rd(0, 0, d);
        chk("R10 func kept others updated", 32'(d), 32'(mk_ctrl(2, 0, 3, 5)));
        chk("R10 pad_func", 32'(pad_func[0 +: FW]), 2);
        wr(0, 0, mk_ctrl(7, 0, 0, 0));
        chk("R10 index 7 rejected", 32'(pad_func[0 +: FW]), 2);
    endtask

    task automatic t_bad_pin();
        logic [15:0] d;
        logic [FW*NP-1:0] f0;
        logic [3*NP-1:0]  dr0;
        f0 = pad_func;
        dr0 = pad_drive;
        for (int p = 6; p < 8; p++) begin
            for (int w = 0; w < 2; w++) begin
                wr(p, w, 16'hFFFF);
                rd(p, w, d);
                chk("R11 unpopulated reads zero", 32'(d), 0);
            end
        end
        chk("R11 func unaffected", 32'(pad_func), 32'(f0));
        chk("R11 drive unaffected", 32'(pad_drive), 32'(dr0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bias();
        t_drive();
        t_data();
        t_sync_keep();
        t_alt();
        t_bad_func();
        t_bad_pin();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule